// File: doc/BRIEF.md
# Clock Synthesizer Frequency Lock Monitor

This block decides whether a clock synthesizer has settled on its target frequency. It takes a reference clock and a feedback clock. The feedback clock is the oscillator output after the synthesis divider, so on a locked loop the two clocks have the same frequency. The monitor compares the two frequencies and ignores their phase. Measurement runs in back-to-back windows of 2^WIN_LOG2 reference cycles, so a lock decision takes longer when the reference is slower.

A free-running binary counter in the feedback domain is published as gray code. The reference domain synchronizes it with two flops, converts it back to binary and takes the difference between the current and the previous window end. That difference is the number of feedback edges in the window.

The lock flag is read-only to software. It rises only after two windows in a row fall within tolerance. It falls after a single window out of tolerance. A window with no feedback edges at all always counts as unlocked. Each change of the lock flag, in either direction, sets a sticky interrupt flag when the enable is high. Software clears that flag by writing one to it. Software either polls the lock flag or waits for the interrupt, and treats the oscillator as stable only while the flag is high.

Top module: `pll_lock_monitor`

## Requirements
- R1: In each window of 2^WIN_LOG2 reference cycles the block counts rising edges of the feedback clock and compares the count with 2^WIN_LOG2 (256 by default). Only frequency is judged: equal periods at any fixed phase offset give a count of exactly 256.
- R2: A window is in tolerance when |count − 256| ≤ tol (the bound is inclusive). `locked` rises only at the end of the second of two consecutive in-tolerance windows.
- R3: A single out-of-tolerance window clears `locked` at the end of that window.
- R4: A window with zero feedback edges clears `locked`, whatever the value of `tol`.
- R5: `locked` changes only on the reference edge that ends a window.
- R6: `irq` is set on the edge where `locked` changes, in either direction, if `irq_en` is 1. It is not set while `irq_en` is 0.
- R7: `irq` is sticky. It clears only on a reference edge where `irq_clr` is 1, and a new set in the same cycle takes priority over the clear.
- R8: When `rst_n` is low, `locked` and `irq` go to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; paces the windows and all status logic |
| fb_clk | input | 1 | Feedback clock (oscillator output after the synthesis divider) |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| tol | input | TOL_W | Allowed deviation of the window count from 2^WIN_LOG2 |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| locked | output | 1 | Lock status flag |
| irq | output | 1 | Sticky lock-change interrupt flag |

## Verification
The bench builds the block with its defaults: 256-cycle windows, a 10-bit gray counter and a 9-bit tolerance. Because `tol` is 9 bits wide, it can exceed the 256 deviation that an idle feedback clock produces. This makes the forced unlock on an empty window observable as behaviour of its own, separate from the normal tolerance check.

A 10-bit count also keeps a feedback clock at twice the reference frequency (512 edges per window) free of wrap-around, so that case is exercised too. Feedback periods are chosen so that counts fall clearly inside or outside each tolerance, apart from the equal-period case, which hits the exact count of 256 under a zero tolerance.

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int WIN_LOG2 = 8,
  parameter int TOL_W    = WIN_LOG2 + 1
) (
  input  logic             ref_clk,
  input  logic             fb_clk,
  input  logic             rst_n,
  input  logic [TOL_W-1:0] tol,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic             locked,
  output logic             irq
);
  localparam int CNT_W = WIN_LOG2 + 2;
  localparam logic [CNT_W-1:0] WIN_CNT = CNT_W'(1 << WIN_LOG2);

  logic [CNT_W-1:0] fb_bin, fb_gray, fb_nxt;
  logic [CNT_W-1:0] sync1, sync2, cur_bin, prev_bin, delta, mag;
  logic [WIN_LOG2-1:0] win_cnt;
  logic win_end, in_tol, good_seen, lock_nxt, irq_flag;

  assign fb_nxt = fb_bin + 1'b1;

  always_ff @(posedge fb_clk or negedge rst_n)
    if (!rst_n) begin
      fb_bin  <= '0;
      fb_gray <= '0;
    end else begin
      fb_bin  <= fb_nxt;
      fb_gray <= fb_nxt ^ (fb_nxt >> 1);
    end

  for (genvar i = 0; i < CNT_W; i++) begin : g_g2b
    assign cur_bin[i] = ^sync2[CNT_W-1:i];
  end

  assign win_end  = &win_cnt;
  assign delta    = cur_bin - prev_bin;
  assign mag      = (delta >= WIN_CNT) ? delta - WIN_CNT : WIN_CNT - delta;
  assign in_tol   = (delta != '0) && (mag <= CNT_W'(tol));
  assign lock_nxt = in_tol && (locked || good_seen);

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      sync1     <= '0;
      sync2     <= '0;
      prev_bin  <= '0;
      win_cnt   <= '0;
      good_seen <= 1'b0;
      locked    <= 1'b0;
      irq_flag  <= 1'b0;
    end else begin
      sync1   <= fb_gray;
      sync2   <= sync1;
      win_cnt <= win_cnt + 1'b1;
      if (win_end) begin
        prev_bin  <= cur_bin;
        good_seen <= in_tol;
        locked    <= lock_nxt;
      end
      if (win_end && irq_en && (lock_nxt != locked)) irq_flag <= 1'b1;
      else if (irq_clr)                             irq_flag <= 1'b0;
    end

  assign irq = irq_flag;
endmodule

module pll_lock_monitor_chk #(
  parameter int CNT_W = 10
) (
  input logic             ref_clk,
  input logic             rst_n,
  input logic             win_end,
  input logic [CNT_W-1:0] delta,
  input logic             good_seen,
  input logic             locked,
  input logic             irq_en,
  input logic             irq_clr,
  input logic             irq
);
  assert_lock_only_at_window_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !win_end |=> $stable(locked));

  assert_rise_needs_two_windows_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(locked) |-> $past(good_seen));

  assert_empty_window_unlocks_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (win_end && delta == '0) |=> !locked);

  assert_irq_cause_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(irq_en) && (locked != $past(locked))));

  assert_irq_sticky_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  assert_irq_clear_cause_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(irq) |-> $past(irq_clr));
endmodule

bind pll_lock_monitor pll_lock_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .ref_clk   (ref_clk),
  .rst_n     (rst_n),
  .win_end   (win_end),
  .delta     (delta),
  .good_seen (good_seen),
  .locked    (locked),
  .irq_en    (irq_en),
  .irq_clr   (irq_clr),
  .irq       (irq)
);

// File: tb/pll_lock_monitor_tb.sv
`timescale 1ns/1ps
module pll_lock_monitor_tb;
  localparam int TOL_W = 9;
  localparam int WAIT3 = 3 * 256 + 12;

  // fields: feedback half period in ps, tol, expected locked
  localparam int VEC [8][3] = '{
    '{5000,  4, 1},
    '{4800,  4, 0},
    '{4800, 15, 1},
    '{5500, 15, 0},
    '{5050,  4, 1},
    '{5150,  4, 0},
    '{2500, 15, 0},
    '{5000,  0, 1}
  };

  logic ref_clk = 1'b0;
  logic fb_clk  = 1'b0;
  logic rst_n   = 1'b0;
  logic [TOL_W-1:0] tol = 9'd8;
  logic irq_en  = 1'b1;
  logic irq_clr = 1'b0;
  logic locked, irq;

  logic fb_run  = 1'b0;
  int   fb_half = 5000;
  int   checks  = 0;
  int   errors  = 0;

  pll_lock_monitor u_dut (
    .ref_clk (ref_clk),
    .fb_clk  (fb_clk),
    .rst_n   (rst_n),
    .tol     (tol),
    .irq_en  (irq_en),
    .irq_clr (irq_clr),
    .locked  (locked),
    .irq     (irq)
  );

  always #5 ref_clk = ~ref_clk;

  always begin
    if (fb_run) begin
      #(fb_half * 0.001) fb_clk = ~fb_clk;
    end else begin
      fb_clk = 1'b0;
      #1;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1;
    wait_n(1);
    irq_clr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2.5 fb_run = 1'b1;
    wait_n(3);
    chk("R8 reset locked", locked, 1'b0);
    chk("R8 reset irq", irq, 1'b0);
    rst_n = 1'b1;

    wait_n(300);
    chk("R2 one good window only", locked, 1'b0);
    wait_n(230);
    chk("R2 locked after two windows", locked, 1'b1);
    chk("R6 irq on rising lock", irq, 1'b1);
    pulse_clr();
    chk("R7 irq cleared by write one", irq, 1'b0);
    chk("R7 clear leaves lock", locked, 1'b1);

    wait_n(9);
    fb_run = 1'b0;
    wait_n(160);
    chk("R5 no change mid window", locked, 1'b1);
    wait_n(80);
    chk("R3 bad window clears lock", locked, 1'b0);
    chk("R6 irq on falling lock", irq, 1'b1);
    tol = 9'd300;
    wait_n(260);
    chk("R4 empty window unlocked with wide tol", locked, 1'b0);
    chk("R7 irq stays set", irq, 1'b1);
    wait_n(260);
    chk("R4 two empty windows still unlocked", locked, 1'b0);

    irq_en = 1'b0;
    pulse_clr();
    tol = 9'd4;
    fb_run = 1'b1;
    wait_n(WAIT3);
    chk("R6 relock", locked, 1'b1);
    chk("R6 no irq when disabled", irq, 1'b0);

    for (int k = 0; k < 8; k++) begin
      fb_half = VEC[k][0];
      tol     = TOL_W'(VEC[k][1]);
      wait_n(WAIT3);
      chk($sformatf("R1 R2 R3 vector %0d", k), locked, VEC[k][2] != 0);
    end

    irq_en = 1'b1;
    fb_half = 4800;
    wait_n(WAIT3);
    chk("R3 drop after vector run", locked, 1'b0);
    chk("R6 irq re-enabled on drop", irq, 1'b1);

    #2 rst_n = 1'b0;
    #1;
    chk("R8 async reset locked", locked, 1'b0);
    chk("R8 async reset irq", irq, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule